// File: doc/BRIEF.md
# Word-Count Beat Dealer and Count Reducer

This block sits at both ends of a bank of parallel word-counting lanes. On the way in, it takes a wide input stream and hands each whole beat to exactly one lane. The lanes take turns in a fixed rotation, and the stream stalls while the lane whose turn it is cannot accept. On the way out, it collects the 32-bit occurrence count that each lane reports. On a fixed schedule it adds those counts into one saturating total. Host software reads that total through a small address/data register port.

A write to the clear register zeroes the total. It also sends a one-cycle clear strobe to all lanes and restarts the summing schedule. Beats are never split. A word that straddles the boundary between two beats lands in two different lanes, and neither lane counts it. Callers that need exact counts must align words to beat boundaries or accept that undercount.

Top module: `wc_sched_reduce`

## Requirements
- R1: At most one bit of `lane_valid_o` is set at a time. That bit belongs to the lane whose turn it is and equals `in_valid_i`. `in_ready_o` equals that lane's bit of `lane_ready_i`, and `lane_data_o` always equals `in_data_i`.
- R2: After reset the turn belongs to lane 0. Each accepted beat (`in_valid_i` and `in_ready_o` both high at a clock edge) passes the turn to the next lane index, and the index wraps from N_LANES-1 to 0.
- R3: While the lane whose turn it is holds its ready low, `in_ready_o` is low and the turn does not move. No other lane is offered the beat.
- R4: The total is reloaded only every RED_PERIOD cycles. The reload takes the sum of all lane counts present at that edge. After a clear, the first reload happens exactly RED_PERIOD cycles after the clear edge.
- R5: If the exact sum exceeds 0xFFFFFFFF, the total becomes 0xFFFFFFFF instead of wrapping. A sum equal to 0xFFFFFFFF is reported exactly.
- R6: A write of any nonzero value to address 1 zeroes the total at the next edge and raises `lane_clr_o` for exactly one cycle. A write of zero to address 1 has no effect.
- R7: Reading address 0 returns the total, and reading any other address returns 0. Writes to any address other than 1 leave the total unchanged and do not raise `lane_clr_o`.
- R8: Out of reset, the total reads 0 and `lane_clr_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_data_i | input | DATA_W | Input stream beat |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high with valid |
| lane_data_o | output | DATA_W | Beat offered to lanes |
| lane_valid_o | output | N_LANES | Per-lane valid, at most one high |
| lane_ready_i | input | N_LANES | Per-lane ready |
| lane_cnt_i | input | N_LANES*CNT_W | Lane counts, lane k at bits k*CNT_W upward |
| lane_clr_o | output | 1 | One-cycle clear strobe to all lanes |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data, combinational from address |

## Verification
The dispatch path has no registers. The bench therefore checks valid, ready and data in the same cycle it drives the input. It checks the lane that takes the turn after each clock edge. The clear strobe and the zeroed total show up one edge after the write, and the strobe is gone one edge later. The first reload after a clear falls on edge RED_PERIOD. The bench checks that the total is still zero after edge RED_PERIOD-1 and holds the sum after edge RED_PERIOD. For the table of count patterns, the bench holds the counts steady for two full periods, so the total is settled before it is read.

// File: rtl/wc_pkg.sv
package wc_pkg;
  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wc_rr_dealer.sv
module wc_rr_dealer #(
  parameter int unsigned N_LANES = 4,
  parameter int unsigned SEL_W   = wc_pkg::sel_width(N_LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  output logic [N_LANES-1:0] lane_valid_o,
  input  logic [N_LANES-1:0] lane_ready_i,
  output logic [SEL_W-1:0]   sel_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_LANES - 1);

  logic [SEL_W-1:0] sel_q;
  logic             fire;

  assign in_ready_o = lane_ready_i[sel_q];
  assign fire       = in_valid_i & in_ready_o;
  assign sel_o      = sel_q;

  for (genvar g = 0; g < N_LANES; g++) begin : g_valid
    assign lane_valid_o[g] = in_valid_i & (sel_q == SEL_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sel_q <= '0;
    else if (fire) begin
      if (sel_q == LAST)      sel_q <= '0;
      else                    sel_q <= sel_q + 1'b1;
    end
  end
endmodule

// File: rtl/wc_period_timer.sv
module wc_period_timer #(
  parameter int unsigned PERIOD = 8,
  parameter int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wc_sat_reducer.sv
module wc_sat_reducer #(
  parameter int unsigned N_LANES = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SUM_W   = CNT_W + wc_pkg::sel_width(N_LANES) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     clr_i,
  input  logic [N_LANES*CNT_W-1:0] lane_cnt_i,
  output logic [CNT_W-1:0]         total_o
);
  localparam logic [SUM_W-1:0] MAX_W = SUM_W'({CNT_W{1'b1}});

  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] sat_sum;
  logic [CNT_W-1:0] total_q;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_LANES; i++)
      sum = sum + SUM_W'(lane_cnt_i[i*CNT_W +: CNT_W]);
  end

  assign sat_sum = (sum > MAX_W) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  assign total_o = total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     total_q <= '0;
    else if (clr_i)  total_q <= '0;
    else if (tick_i) total_q <= sat_sum;
  end
endmodule

// File: rtl/wc_sched_reduce.sv
module wc_sched_reduce #(
  parameter int unsigned DATA_W     = 256,
  parameter int unsigned N_LANES    = 4,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned RED_PERIOD = 8,
  parameter int unsigned ADDR_W     = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DATA_W-1:0]        in_data_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  output logic [DATA_W-1:0]        lane_data_o,
  output logic [N_LANES-1:0]       lane_valid_o,
  input  logic [N_LANES-1:0]       lane_ready_i,
  input  logic [N_LANES*CNT_W-1:0] lane_cnt_i,
  output logic                     lane_clr_o,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic                     reg_wr_i,
  input  logic [CNT_W-1:0]         reg_wdata_i,
  output logic [CNT_W-1:0]         reg_rdata_o
);
  localparam int unsigned SEL_W = wc_pkg::sel_width(N_LANES);
  localparam logic [ADDR_W-1:0] A_TOTAL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(1);

  logic [SEL_W-1:0] sel_q;
  logic             tick;
  logic             clr_req;
  logic             clr_q;
  logic [CNT_W-1:0] total_q;

  assign lane_data_o = in_data_i;
  assign clr_req     = reg_wr_i && (reg_addr_i == A_CLEAR) && (reg_wdata_i != '0);
  assign reg_rdata_o = (reg_addr_i == A_TOTAL) ? total_q : '0;
  assign lane_clr_o  = clr_q;

  wc_rr_dealer #(.N_LANES(N_LANES), .SEL_W(SEL_W)) u_dealer (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .lane_valid_o(lane_valid_o), .lane_ready_i(lane_ready_i), .sel_o(sel_q)
  );

  wc_period_timer #(.PERIOD(RED_PERIOD)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(clr_req), .tick_o(tick)
  );

  wc_sat_reducer #(.N_LANES(N_LANES), .CNT_W(CNT_W)) u_reduce (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .clr_i(clr_req),
    .lane_cnt_i(lane_cnt_i), .total_o(total_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= clr_req;
  end
endmodule

// File: rtl/wc_sched_reduce_chk.sv
module wc_sched_reduce_chk #(
  parameter int unsigned N_LANES = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SEL_W   = wc_pkg::sel_width(N_LANES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic [N_LANES-1:0] lane_valid_o,
  input logic [N_LANES-1:0] lane_ready_i,
  input logic [SEL_W-1:0]   sel_q,
  input logic               tick,
  input logic               clr_req,
  input logic [CNT_W-1:0]   total_q,
  input logic               lane_clr_o
);
  assert_onehot_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_valid_o));

  assert_handshake_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> ($countones(lane_valid_o & lane_ready_i) == 1));

  assert_turn_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && sel_q != SEL_W'(N_LANES - 1)) |=> (sel_q == $past(sel_q) + 1'b1));

  assert_stall_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> $stable(sel_q));

  assert_total_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !clr_req) |=> $stable(total_q));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req |=> (total_q == '0 && lane_clr_o));
endmodule

bind wc_sched_reduce wc_sched_reduce_chk #(.N_LANES(N_LANES), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .lane_valid_o(lane_valid_o), .lane_ready_i(lane_ready_i), .sel_q(sel_q),
  .tick(tick), .clr_req(clr_req), .total_q(total_q), .lane_clr_o(lane_clr_o)
);

// File: tb/tb_wc_sched_reduce.sv
module tb_wc_sched_reduce;
  localparam int unsigned DATA_W = 256;
  localparam int unsigned N      = 4;
  localparam int unsigned CW     = 32;
  localparam int unsigned RP     = 8;
  localparam int unsigned NV     = 7;

  // {c0, c1, c2, c3, expected total}
  localparam logic [159:0] VEC [0:NV-1] = '{
    {32'd1, 32'd2, 32'd3, 32'd4, 32'd10},
    {32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    {32'd100, 32'd0, 32'd0, 32'd7, 32'd107},
    {32'hFFFFFFFF, 32'd0, 32'd0, 32'd0, 32'hFFFFFFFF},
    {32'hFFFFFFFF, 32'd1, 32'd0, 32'd0, 32'hFFFFFFFF},
    {32'h80000000, 32'h80000000, 32'd0, 32'd0, 32'hFFFFFFFF},
    {32'h7FFFFFFF, 32'h7FFFFFFF, 32'd1, 32'd0, 32'hFFFFFFFF}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] lane_data;
  logic [N-1:0]      lane_valid;
  logic [N-1:0]      lane_ready = '1;
  logic [N*CW-1:0]   lane_cnt = '0;
  logic              lane_clr;
  logic [1:0]        reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [CW-1:0]     reg_wdata = '0;
  logic [CW-1:0]     reg_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  wc_sched_reduce #(.DATA_W(DATA_W), .N_LANES(N), .CNT_W(CW), .RED_PERIOD(RP), .ADDR_W(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .lane_data_o(lane_data), .lane_valid_o(lane_valid), .lane_ready_i(lane_ready),
    .lane_cnt_i(lane_cnt), .lane_clr_o(lane_clr), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic read_total(output logic [CW-1:0] v);
    reg_addr = 2'd0;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_wdata = '0; reg_addr = 2'd0;
    #1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    #35;
    // R8: reset state
    read_total(v);
    chk("R8 total after reset", v, '0);
    chk("R8 clr after reset", {31'd0, lane_clr}, 32'd0);
    rst_n = 1'b1;
    step();

    // R4 R5: table of count patterns
    for (int i = 0; i < NV; i++) begin
      lane_cnt = VEC[i][159:32];
      for (int k = 0; k < 2 * RP; k++) step();
      read_total(v);
      chk($sformatf("R4/R5 vec %0d", i), v, VEC[i][31:0]);
    end

    // R7: other address reads 0, write to address 0 ignored
    lane_cnt = {32'd0, 32'd0, 32'd5, 32'd6};
    for (int k = 0; k < 2 * RP; k++) step();
    reg_addr = 2'd3; #1;
    chk("R7 read addr3", reg_rdata, '0);
    wr(2'd0, 32'h55);
    read_total(v);
    chk("R7 write addr0 ignored", v, 32'd11);
    chk("R7 no clr on addr0 write", {31'd0, lane_clr}, 32'd0);

    // R6: zero write to clear register ignored
    wr(2'd1, 32'd0);
    read_total(v);
    chk("R6 zero write ignored", v, 32'd11);
    chk("R6 no strobe on zero write", {31'd0, lane_clr}, 32'd0);

    // R6 + R4: clear, strobe, reload exactly RP edges later
    wr(2'd1, 32'd1);
    read_total(v);
    chk("R6 total zeroed", v, '0);
    chk("R6 strobe high", {31'd0, lane_clr}, 32'd1);
    step();
    chk("R6 strobe one cycle", {31'd0, lane_clr}, 32'd0);
    for (int k = 2; k < RP; k++) step();
    read_total(v);
    chk("R4 no reload before period", v, '0);
    step();
    read_total(v);
    chk("R4 reload at period", v, 32'd11);

    // R1 R2: dispatch rotation with all lanes ready
    lane_ready = '1;
    for (int b = 0; b < 6; b++) begin
      in_data = {8{32'hA000_0000 + 32'(b)}};
      in_valid = 1'b1;
      #1;
      chk($sformatf("R2 beat %0d lane", b), {28'd0, lane_valid}, 32'(1 << (b % N)));
      chk("R1 ready", {31'd0, in_ready}, 32'd1);
      chk("R1 data", lane_data[31:0], 32'hA000_0000 + 32'(b));
      step();
    end
    in_valid = 1'b0;

    // R3: turn is at lane 2, hold it not ready
    lane_ready = 4'b1011;
    in_valid = 1'b1;
    in_data = {8{32'hBEEF_0002}};
    #1;
    for (int k = 0; k < 3; k++) begin
      chk("R3 stall ready low", {31'd0, in_ready}, 32'd0);
      chk("R3 offered only to turn lane", {28'd0, lane_valid}, 32'h4);
      step();
      #1;
    end
    lane_ready = 4'b1111;
    #1;
    chk("R3 accepted when ready", {31'd0, in_ready}, 32'd1);
    step();
    #1;
    chk("R3 turn moves to lane 3", {28'd0, lane_valid}, 32'h8);
    step();
    #1;
    chk("R2 wrap to lane 0", {28'd0, lane_valid}, 32'h1);
    in_valid = 1'b0;
    #1;
    chk("R1 no valid when idle", {28'd0, lane_valid}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule